// File: doc/BRIEF.md
# Reference Clock Failover Switch

The block forwards one of two reference clocks, input A and input B, to a single output clock. A static select input names which of the two is the primary; the other is the backup. Under normal conditions the output carries the primary.

Each input is watched from a free-running monitor clock. When the primary stops toggling for a programmable number of monitor cycles, the block moves the output to the backup without producing a runt pulse. When the primary starts toggling again, the block stays on the backup until it has counted a fixed number of rising edges of the primary, 1024 by default. A second dropout of the primary during that window starts the count again from zero. A status output tells which input currently drives the output.

Top module: `refclk_failover`

## Requirements
- R1: With `primSel` = 1 input A is the primary, and with `primSel` = 0 input B is the primary. After reset the output carries the primary's period, and `srcIsA` is 1 exactly when input A drives the output.
- R2: If the primary shows no edge for `LOSS_LIMIT` monitor cycles, the output moves to the backup and `srcIsA` follows. The silent input's leg enable is forced off.
- R3: Every handover is glitch-free. No high or low phase of `clkOut` is shorter than the shorter input half-period, and the two leg enables are never on together.
- R4: Once the primary toggles again, the output stays on the backup until `REQUAL_EDGES` rising edges of the primary have been seen. After that it returns to the primary within a few cycles.
- R5: If the primary falls silent again before its requalification count completes, the count restarts from zero.
- R6: Loss of the backup while the output is on the primary has no effect on `clkOut` or `srcIsA`.
- R7: While `rstN` is low, both leg enables are off, `clkOut` is low and `srcIsA` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Reference clock input A |
| clkB | input | 1 | Reference clock input B |
| monClk | input | 1 | Free-running monitor clock; must run at least twice as fast as either input |
| rstN | input | 1 | Active-low asynchronous reset |
| primSel | input | 1 | Primary choice: 1 selects A, 0 selects B. Tie high when unused |
| clkOut | output | 1 | Forwarded reference clock |
| srcIsA | output | 1 | 1 when input A drives `clkOut`, 0 otherwise |

## Verification
The assertions assume that `primSel` changes only while reset is held. They also assume that an input which stops toggling comes to rest low, and that `LOSS_LIMIT` monitor cycles are longer than an input half-period. The stimulus meets these conditions. It changes `primSel` only inside a reset pulse. It stops each input clock only after that clock has finished its high phase. It uses input periods of 40 ns and 41 ns against a 4 ns monitor clock. Switch-over timing is sampled well clear of each expected transition: about 1000 and about 1040 primary edges after a restart.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  localparam int LEG_A = 0;
  localparam int LEG_B = 1;

  // Strobes from the control to the datapath (monitor clock domain)
  typedef struct packed {
    logic       pickA;    // 1: route input A, 0: route input B
    logic [1:0] killLeg;  // per leg: input found silent, clear its enable
  } refsw_ctrl_t;
endpackage

// File: rtl/refsw_activity.sv
module refsw_activity #(
  parameter int LOSS_LIMIT = 16
) (
  input  logic monClk,
  input  logic rstN,
  input  logic clkIn,
  output logic alive,
  output logic risePulse
);
  localparam int CW = $clog2(LOSS_LIMIT + 1);
  localparam logic [CW-1:0] QUIET_MAX = CW'(LOSS_LIMIT);

  logic [2:0]    syncQ;
  logic [CW-1:0] quietCnt;
  logic          toggled;

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], clkIn};
  end

  assign toggled   = syncQ[2] ^ syncQ[1];
  assign risePulse = syncQ[1] & ~syncQ[2];

  // R2: the input is declared dead after LOSS_LIMIT monitor cycles without an edge
  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      alive    <= 1'b1;
    end else if (toggled) begin
      quietCnt <= '0;
      alive    <= 1'b1;
    end else if (quietCnt == QUIET_MAX) begin
      alive    <= 1'b0;
    end else begin
      quietCnt <= quietCnt + 1'b1;
    end
  end
endmodule

// File: rtl/refsw_leg.sv
module refsw_leg (
  input  logic legClk,
  input  logic rstN,
  input  logic kill,
  input  logic want,
  input  logic otherEn,
  output logic en
);
  logic clrN;
  logic stage1;

  assign clrN = rstN & ~kill;

  // R3: the enable changes only on the leg's falling edge, after the other leg is off
  always_ff @(negedge legClk or negedge clrN) begin
    if (!clrN) begin
      stage1 <= 1'b0;
      en     <= 1'b0;
    end else begin
      stage1 <= want & ~otherEn;
      en     <= stage1;
    end
  end
endmodule

// File: rtl/refsw_datapath.sv
module refsw_datapath
  import refsw_pkg::*;
#(
  parameter int LOSS_LIMIT = 16
) (
  input  logic        monClk,
  input  logic        rstN,
  input  logic        clkA,
  input  logic        clkB,
  input  refsw_ctrl_t ctrlS,
  output logic [1:0]  alive,
  output logic [1:0]  rise,
  output logic [1:0]  legEn,
  output logic        clkOut,
  output logic        srcIsA
);
  logic [1:0] clkVec;
  logic [1:0] wantLeg;
  logic [1:0] statSync;

  assign clkVec  = {clkB, clkA};
  assign wantLeg = {~ctrlS.pickA, ctrlS.pickA};

  for (genvar i = 0; i < 2; i++) begin : g_leg
    logic legClk;
    assign legClk = clkVec[i];

    refsw_activity #(.LOSS_LIMIT(LOSS_LIMIT)) u_act (
      .monClk   (monClk),
      .rstN     (rstN),
      .clkIn    (legClk),
      .alive    (alive[i]),
      .risePulse(rise[i])
    );

    refsw_leg u_leg (
      .legClk (legClk),
      .rstN   (rstN),
      .kill   (ctrlS.killLeg[i]),
      .want   (wantLeg[i]),
      .otherEn(legEn[1-i]),
      .en     (legEn[i])
    );
  end

  assign clkOut = |(clkVec & legEn);

  // R1: the status reflects the enable of leg A, brought into the monitor domain
  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) statSync <= '0;
    else       statSync <= {statSync[0], legEn[LEG_A]};
  end
  assign srcIsA = statSync[1];
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int REQUAL_EDGES = 1024
) (
  input  logic        monClk,
  input  logic        rstN,
  input  logic        primSel,
  input  logic [1:0]  alive,
  input  logic [1:0]  rise,
  output refsw_ctrl_t ctrlS
);
  localparam int QW = $clog2(REQUAL_EDGES + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(REQUAL_EDGES - 1);

  logic          primIdx;
  logic          primAlive;
  logic          primRise;
  logic          onPrim;
  logic [QW-1:0] qualCnt;
  logic [1:0]    killQ;

  assign primIdx   = ~primSel;  // 0 selects leg A, 1 selects leg B (R1)
  assign primAlive = alive[primIdx];
  assign primRise  = rise[primIdx];

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      onPrim  <= 1'b1;
      qualCnt <= '0;
    end else if (onPrim) begin
      if (!primAlive) begin          // R2
        onPrim  <= 1'b0;
        qualCnt <= '0;
      end
    end else if (!primAlive) begin   // R5: restart the window
      qualCnt <= '0;
    end else if (primRise) begin     // R4
      if (qualCnt == QUAL_LAST) begin
        onPrim  <= 1'b1;
        qualCnt <= '0;
      end else begin
        qualCnt <= qualCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) killQ <= '0;
    else       killQ <= ~alive;
  end

  assign ctrlS.pickA   = onPrim ? primSel : ~primSel;
  assign ctrlS.killLeg = killQ;
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import refsw_pkg::*;
#(
  parameter int LOSS_LIMIT   = 16,
  parameter int REQUAL_EDGES = 1024
) (
  input  logic clkA,
  input  logic clkB,
  input  logic monClk,
  input  logic rstN,
  input  logic primSel,
  output logic clkOut,
  output logic srcIsA
);
  refsw_ctrl_t ctrlS;
  logic [1:0]  alive;
  logic [1:0]  rise;
  logic [1:0]  legEn;

  refsw_ctrl #(.REQUAL_EDGES(REQUAL_EDGES)) u_ctrl (
    .monClk (monClk),
    .rstN   (rstN),
    .primSel(primSel),
    .alive  (alive),
    .rise   (rise),
    .ctrlS  (ctrlS)
  );

  refsw_datapath #(.LOSS_LIMIT(LOSS_LIMIT)) u_dp (
    .monClk(monClk),
    .rstN  (rstN),
    .clkA  (clkA),
    .clkB  (clkB),
    .ctrlS (ctrlS),
    .alive (alive),
    .rise  (rise),
    .legEn (legEn),
    .clkOut(clkOut),
    .srcIsA(srcIsA)
  );
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk
  import refsw_pkg::*;
(
  input logic        monClk,
  input logic        rstN,
  input logic        primSel,
  input refsw_ctrl_t ctrlS,
  input logic [1:0]  alive,
  input logic [1:0]  legEn
);
  logic primAlive;
  logic onPrimary;
  assign primAlive = primSel ? alive[LEG_A] : alive[LEG_B];
  assign onPrimary = (ctrlS.pickA == primSel);

  p_legs_exclusive_r3: assert property (@(posedge monClk) disable iff (!rstN)
    $onehot0(legEn));

  p_loss_moves_r2: assert property (@(posedge monClk) disable iff (!rstN)
    !primAlive |=> !onPrimary);

  p_dead_leg_off_r2: assert property (@(posedge monClk) disable iff (!rstN)
    ctrlS.killLeg[LEG_A] |-> !legEn[LEG_A]);

  p_return_when_alive_r4: assert property (@(posedge monClk) disable iff (!rstN)
    (onPrimary && !$past(onPrimary)) |-> $past(primAlive));

  p_reset_quiet_r7: assert property (@(posedge monClk)
    !rstN |-> (legEn == 2'b00));
endmodule

bind refclk_failover refclk_failover_chk u_chk (
  .monClk (monClk),
  .rstN   (rstN),
  .primSel(primSel),
  .ctrlS  (ctrlS),
  .alive  (alive),
  .legEn  (legEn)
);

// File: tb/test_refclk_failover.sv
`timescale 1ns/1ps
module test_refclk_failover;
  logic monClk = 1'b0;
  logic clkA = 1'b0, clkB = 1'b0;
  logic runA = 1'b1, runB = 1'b1;
  logic rstN = 1'b0;
  logic primSel = 1'b1;
  logic clkOut, srcIsA;

  int nChecks = 0;
  int nFail = 0;

  refclk_failover i_refclk_failover (
    .clkA(clkA), .clkB(clkB), .monClk(monClk), .rstN(rstN),
    .primSel(primSel), .clkOut(clkOut), .srcIsA(srcIsA)
  );

  always #2ns monClk = ~monClk;                       // 250 MHz
  always begin
    if (runA) begin #20ns clkA = 1'b1; #20ns clkA = 1'b0; end
    else #4ns;
  end
  always begin
    if (runB) begin #20.5ns clkB = 1'b1; #20.5ns clkB = 1'b0; end
    else #4ns;
  end

  // Scoreboard for the status flag
  typedef struct { string req; logic val; } exp_t;
  exp_t expQ[$];

  always @(negedge monClk) begin
    if (expQ.size() > 0) begin
      exp_t item;
      item = expQ.pop_front();
      nChecks++;
      if (srcIsA !== item.val) begin
        nFail++;
        $display("FAIL %s srcIsA: actual %b expected %b", item.req, srcIsA, item.val);
      end
    end
  end

  task automatic expectSrc(string req, logic val);
    exp_t item;
    item.req = req;
    item.val = val;
    expQ.push_back(item);
    while (expQ.size() != 0) @(posedge monClk);
  endtask

  task automatic checkVal(string req, string what, real act, real exp, real tol);
    nChecks++;
    if (act > exp + tol || act < exp - tol) begin
      nFail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic checkPeriod(string req, real expNs);
    realtime t0;
    @(posedge clkOut); t0 = $realtime;
    @(posedge clkOut);
    checkVal(req, "clkOut period ns", $realtime - t0, expNs, 0.25);
  endtask

  task automatic edgesA(int n); repeat (n) @(posedge clkA); endtask
  task automatic edgesB(int n); repeat (n) @(posedge clkB); endtask

  // Phase monitor for R3
  logic armed = 1'b0;
  realtime lastT = 0.0;
  real minPhase = 1.0e9;
  int shortCnt = 0;
  always @(clkOut) begin
    real d;
    d = $realtime - lastT;
    if (armed && lastT > 0.0) begin
      if (d < minPhase) minPhase = d;
      if (d < 19.5) shortCnt++;
    end
    lastT = $realtime;
  end

  initial begin
    repeat (190000) @(posedge monClk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R7: reset state
    #100ns;
    checkVal("R7", "clkOut in reset", clkOut, 0.0, 0.1);
    expectSrc("R7", 1'b0);
    rstN = 1'b1;
    #300ns armed = 1'b1;
    #2us;
    // R1: A is the primary when primSel is 1
    expectSrc("R1", 1'b1);
    checkPeriod("R1", 40.0);

    // R2: primary A lost
    runA = 1'b0;
    #1us;
    expectSrc("R2", 1'b0);
    checkPeriod("R2", 41.0);

    // R4: requalification window
    runA = 1'b1;
    edgesA(1000);
    expectSrc("R4", 1'b0);
    edgesA(40);
    expectSrc("R4", 1'b1);
    checkPeriod("R4", 40.0);

    // R5: dropout inside the window restarts the count
    runA = 1'b0;
    #1us;
    expectSrc("R2", 1'b0);
    runA = 1'b1;
    edgesA(600);
    runA = 1'b0;
    #400ns;
    runA = 1'b1;
    edgesA(1000);
    expectSrc("R5", 1'b0);
    edgesA(40);
    expectSrc("R5", 1'b1);

    // R6: backup loss while on primary
    runB = 1'b0;
    #1us;
    expectSrc("R6", 1'b1);
    checkPeriod("R6", 40.0);
    runB = 1'b1;
    #1us;

    // Second reset, B as primary
    armed = 1'b0;
    rstN = 1'b0;
    primSel = 1'b0;
    #100ns;
    checkVal("R7", "clkOut in reset", clkOut, 0.0, 0.1);
    expectSrc("R7", 1'b0);
    rstN = 1'b1;
    #300ns armed = 1'b1;
    #2us;
    expectSrc("R1", 1'b0);
    checkPeriod("R1", 41.0);

    runB = 1'b0;
    #1us;
    expectSrc("R2", 1'b1);
    checkPeriod("R2", 40.0);
    runB = 1'b1;
    edgesB(1000);
    expectSrc("R4", 1'b1);
    edgesB(40);
    expectSrc("R4", 1'b0);
    checkPeriod("R4", 41.0);

    // R3: no runt phase seen on clkOut
    checkVal("R3", "short phases", shortCnt, 0.0, 0.1);
    nChecks++;
    if (minPhase < 19.5) begin
      nFail++;
      $display("FAIL R3 min phase: actual %0.3f expected >= 19.500", minPhase);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule